// File: doc/BRIEF.md
# Serial Port Interrupt and Power-Mode Controller

This block gathers the event pulses from the transmit and receive datapaths of a serial port. It holds them as sticky status flags in two 8-bit status words. Software clears a flag by writing a one to its bit. Each flag is gated by its own enable bit, and the gated flags are ORed onto a single active-high interrupt line. The block also watches the raw receive pin through its own synchronizer and edge detector. That detector has selectable polarity.

The block also decides when the transmit and receive engines may run. It produces an engine clock-enable that drops in two cases: at once in CPU stop mode, and in CPU wait mode when the stop-in-wait control is set. The register state is kept while the engines are frozen, so they pick up where they left off. The receive-pin edge detector keeps sampling in both low-power modes. When it sees an edge, it raises a wake request.

Top module: `uart_irq_pwr`

## Requirements
- R1: After reset both status words read 0x00 and `irq_o` and `wake_o` are low.
- R2: Status word 1 holds tx-empty at bit 7, tx-done at bit 6, rx-full at bit 5, idle at bit 4 and overrun at bit 3. Bits 2..0 always read 0. A one-cycle event pulse sets its bit, and the set bit is visible after the next rising clock edge.
- R3: Status word 2 holds the receive-edge flag at bit 7, the single-wire bit-error flag at bit 1 and the break flag at bit 0. Bits 6..2 always read 0.
- R4: A one on a bit of `stat1_w1c_i`/`stat2_w1c_i` clears that flag at the next edge. A zero on that bit leaves the flag unchanged. If an event and a clear arrive in the same cycle, the flag ends up set.
- R5: `irq_o` is high, combinationally, when any flag is set while its enable bit in `irq_en_i` is set. The enable bits map as follows: bit 0 tx-empty, bit 1 tx-done, bit 2 rx-full and overrun, bit 3 idle, bit 4 edge, bit 5 bit-error, bit 6 break.
- R6: With `rx_pol_i`=0 a falling edge on `rx_pin_i` is an active edge, and with `rx_pol_i`=1 a rising edge is. The opposite edge is ignored. The edge flag is visible after the third rising clock edge following the pin change (two synchronizer stages plus the flag register).
- R7: While `stop_i` is high, `eng_clk_en_o` is low in the same cycle, whatever the other mode inputs are.
- R8: In wait mode, `eng_clk_en_o` is low when `stop_in_wait_i` is set and high when it is clear. `eng_clk_en_o` is high whenever neither wait nor stop applies.
- R9: The edge detector keeps running while `eng_clk_en_o` is low. `wake_o` is high when the edge flag is set and `eng_clk_en_o` is low.
- R10: Asserting `rst_ni` during stop mode clears every flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_empty_evt_i | input | 1 | Pulse: transmit data moved to the shifter |
| tx_done_evt_i | input | 1 | Pulse: transmission complete |
| rx_full_evt_i | input | 1 | Pulse: received byte available |
| rx_ovr_evt_i | input | 1 | Pulse: receive overrun |
| rx_idle_evt_i | input | 1 | Pulse: receive line went idle |
| bit_err_evt_i | input | 1 | Pulse: single-wire transmit/receive mismatch |
| brk_evt_i | input | 1 | Pulse: break character received |
| rx_pin_i | input | 1 | Raw asynchronous receive pin |
| rx_pol_i | input | 1 | Receive polarity; selects the active edge |
| irq_en_i | input | 7 | Per-source interrupt enables |
| stat1_w1c_i | input | 8 | Write-one-to-clear strobe for status word 1 |
| stat2_w1c_i | input | 8 | Write-one-to-clear strobe for status word 2 |
| wait_i | input | 1 | CPU is in wait mode |
| stop_i | input | 1 | CPU is in stop mode |
| stop_in_wait_i | input | 1 | Freeze the engines in wait mode |
| stat1_o | output | 8 | Status word 1 |
| stat2_o | output | 8 | Status word 2 |
| irq_o | output | 1 | Combined interrupt request |
| eng_clk_en_o | output | 1 | Clock-enable for the tx/rx engines |
| wake_o | output | 1 | Wake request from the receive-edge detector |

## Verification
The outputs are due at three different times. Event pulses and clears show in the status words one rising edge after they are driven. The interrupt line and the engine clock-enable follow their inputs in the same cycle. A receive-pin change reaches the edge flag only on the third rising edge. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the edge where each result is due. For the receive pin it also checks one edge early, to show that the flag has not arrived before its latency.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int STAT_W   = 8;
  localparam int EN_W     = 7;
  localparam int SYNC_LEN = 2;

  // status word 1 bit positions
  localparam int S1_TXE  = 7;
  localparam int S1_TXC  = 6;
  localparam int S1_RXF  = 5;
  localparam int S1_IDL  = 4;
  localparam int S1_OVR  = 3;
  // status word 2 bit positions
  localparam int S2_EDG  = 7;
  localparam int S2_BER  = 1;
  localparam int S2_BRK  = 0;

  // enable vector positions
  localparam int EN_TXE  = 0;
  localparam int EN_TXC  = 1;
  localparam int EN_RXF  = 2;
  localparam int EN_IDL  = 3;
  localparam int EN_EDG  = 4;
  localparam int EN_BER  = 5;
  localparam int EN_BRK  = 6;

  localparam logic [STAT_W-1:0] S1_IMPL = 8'b1111_1000;
  localparam logic [STAT_W-1:0] S2_IMPL = 8'b1000_0011;
endpackage

// File: rtl/uart_irq_flag_bank.sv
module uart_irq_flag_bank #(
  parameter int             W    = 8,
  parameter logic [W-1:0]   IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic unused_bits;
  assign unused_bits = ^{set_i & ~IMPL, clr_i & ~IMPL};

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;   // set wins over clear
        else if (clr_i[i]) q <= 1'b0;
      end
      assign q_o[i] = q;

      AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[i] |=> q_o[i]); // R4
      AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[i] && !set_i[i]) |=> !q_o[i]); // R4
      AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i[i] && !set_i[i]) |=> (q_o[i] == $past(q_o[i]))); // R4
    end else begin : g_zero
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_edge_det.sv
module uart_irq_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign s      = sync_q[STAGES-1];
  // pol 0: falling is active, pol 1: rising is active
  assign edge_o = pol_i ? (s & ~prev_q) : (~s & prev_q);

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && $stable(pol_i)) |=> !edge_o); // R6
endmodule

// File: rtl/uart_irq_pwr.sv
module uart_irq_pwr_gate (
  input  logic wait_i,
  input  logic stop_i,
  input  logic stop_in_wait_i,
  output logic eng_clk_en_o
);
  assign eng_clk_en_o = ~(stop_i | (wait_i & stop_in_wait_i));
endmodule

// File: rtl/uart_irq_pwr_top.sv
module uart_irq_pwr
  import uart_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_empty_evt_i,
  input  logic              tx_done_evt_i,
  input  logic              rx_full_evt_i,
  input  logic              rx_ovr_evt_i,
  input  logic              rx_idle_evt_i,
  input  logic              bit_err_evt_i,
  input  logic              brk_evt_i,
  input  logic              rx_pin_i,
  input  logic              rx_pol_i,
  input  logic [EN_W-1:0]   irq_en_i,
  input  logic [STAT_W-1:0] stat1_w1c_i,
  input  logic [STAT_W-1:0] stat2_w1c_i,
  input  logic              wait_i,
  input  logic              stop_i,
  input  logic              stop_in_wait_i,
  output logic [STAT_W-1:0] stat1_o,
  output logic [STAT_W-1:0] stat2_o,
  output logic              irq_o,
  output logic              eng_clk_en_o,
  output logic              wake_o
);
  logic [STAT_W-1:0] set1, set2;
  logic              rx_edge;

  uart_irq_edge_det #(.STAGES(SYNC_LEN)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (rx_pin_i),
    .pol_i  (rx_pol_i),
    .edge_o (rx_edge)
  );

  always_comb begin
    set1         = '0;
    set1[S1_TXE] = tx_empty_evt_i;
    set1[S1_TXC] = tx_done_evt_i;
    set1[S1_RXF] = rx_full_evt_i;
    set1[S1_IDL] = rx_idle_evt_i;
    set1[S1_OVR] = rx_ovr_evt_i;
    set2         = '0;
    set2[S2_EDG] = rx_edge;
    set2[S2_BER] = bit_err_evt_i;
    set2[S2_BRK] = brk_evt_i;
  end

  uart_irq_flag_bank #(.W(STAT_W), .IMPL(S1_IMPL)) u_stat1 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set1),
    .clr_i  (stat1_w1c_i),
    .q_o    (stat1_o)
  );

  uart_irq_flag_bank #(.W(STAT_W), .IMPL(S2_IMPL)) u_stat2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set2),
    .clr_i  (stat2_w1c_i),
    .q_o    (stat2_o)
  );

  // overrun shares the receive-full enable
  assign irq_o = (stat1_o[S1_TXE] & irq_en_i[EN_TXE])
               | (stat1_o[S1_TXC] & irq_en_i[EN_TXC])
               | ((stat1_o[S1_RXF] | stat1_o[S1_OVR]) & irq_en_i[EN_RXF])
               | (stat1_o[S1_IDL] & irq_en_i[EN_IDL])
               | (stat2_o[S2_EDG] & irq_en_i[EN_EDG])
               | (stat2_o[S2_BER] & irq_en_i[EN_BER])
               | (stat2_o[S2_BRK] & irq_en_i[EN_BRK]);

  uart_irq_pwr_gate u_pwr (
    .wait_i         (wait_i),
    .stop_i         (stop_i),
    .stop_in_wait_i (stop_in_wait_i),
    .eng_clk_en_o   (eng_clk_en_o)
  );

  assign wake_o = stat2_o[S2_EDG] & ~eng_clk_en_o;

  AST_STOP_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !eng_clk_en_o); // R7
  AST_RUN_WHEN_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_i && !wait_i) |-> eng_clk_en_o); // R8
  AST_WAIT_NO_SIW_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && !stop_in_wait_i && !stop_i) |-> eng_clk_en_o); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == '0) |-> !irq_o); // R5
  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat1_o & ~S1_IMPL) == '0) && ((stat2_o & ~S2_IMPL) == '0)); // R3
  AST_WAKE_ONLY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_clk_en_o |-> !wake_o); // R9
endmodule

// File: tb/uart_irq_pwr_tb.sv
module uart_irq_pwr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_txe = 0, ev_txc = 0, ev_rxf = 0, ev_ovr = 0, ev_idl = 0, ev_ber = 0, ev_brk = 0;
  logic       rx_pin = 1'b1, rx_pol = 1'b0;
  logic [6:0] irq_en = '0;
  logic [7:0] w1c1 = '0, w1c2 = '0;
  logic       wt = 0, stp = 0, siw = 0;
  logic [7:0] s1, s2;
  logic       irq, ceng, wake;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  uart_irq_pwr dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_empty_evt_i(ev_txe), .tx_done_evt_i(ev_txc), .rx_full_evt_i(ev_rxf),
    .rx_ovr_evt_i(ev_ovr), .rx_idle_evt_i(ev_idl), .bit_err_evt_i(ev_ber),
    .brk_evt_i(ev_brk), .rx_pin_i(rx_pin), .rx_pol_i(rx_pol), .irq_en_i(irq_en),
    .stat1_w1c_i(w1c1), .stat2_w1c_i(w1c2), .wait_i(wt), .stop_i(stp),
    .stop_in_wait_i(siw), .stat1_o(s1), .stat2_o(s2), .irq_o(irq),
    .eng_clk_en_o(ceng), .wake_o(wake)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_evt(int k, logic v);
    case (k)
      0: ev_txe = v; 1: ev_txc = v; 2: ev_rxf = v; 3: ev_idl = v;
      4: ev_ovr = v; 5: ev_ber = v; default: ev_brk = v;
    endcase
  endtask

  // expected positions from R2/R3, enable bit from R5
  function automatic logic [7:0] exp_s1(int k);
    case (k) 0: return 8'h80; 1: return 8'h40; 2: return 8'h20; 3: return 8'h10;
      4: return 8'h08; default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] exp_s2(int k);
    case (k) 5: return 8'h02; 6: return 8'h01; default: return 8'h00; endcase
  endfunction
  function automatic int en_bit(int k);
    case (k) 0: return 0; 1: return 1; 2: return 2; 3: return 3;
      4: return 2; 5: return 5; default: return 6; endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #3 rst_n = 1'b0;
    step(); step();
    chk("R1 stat1", s1, 0); chk("R1 stat2", s2, 0);
    chk("R1 irq", irq, 0); chk("R1 wake", wake, 0);
    rst_n = 1'b1;
    step();
    chk("R1 stat1 after release", s1, 0);

    // R2 R3 R5: each source, full enable sweep, then clearing (R4)
    for (int k = 0; k < 7; k++) begin
      set_evt(k, 1'b1); step(); set_evt(k, 1'b0);
      chk("R2 stat1 set", s1, exp_s1(k));
      chk("R3 stat2 set", s2, exp_s2(k));
      for (int m = 0; m < 128; m++) begin
        irq_en = 7'(m); #1;
        chk("R5 irq mask", irq, m[en_bit(k)]);
      end
      irq_en = '0;
      w1c1 = ~exp_s1(k); w1c2 = ~exp_s2(k); step(); w1c1 = '0; w1c2 = '0;
      chk("R4 zero write keeps s1", s1, exp_s1(k));
      chk("R4 zero write keeps s2", s2, exp_s2(k));
      w1c1 = exp_s1(k); w1c2 = exp_s2(k); step(); w1c1 = '0; w1c2 = '0;
      chk("R4 clear s1", s1, 0); chk("R4 clear s2", s2, 0);
    end

    // R4 set wins over clear
    ev_rxf = 1; w1c1 = 8'h20; ev_brk = 1; w1c2 = 8'h01; step();
    ev_rxf = 0; w1c1 = 0; ev_brk = 0; w1c2 = 0;
    chk("R4 set wins s1", s1, 8'h20); chk("R4 set wins s2", s2, 8'h01);
    w1c1 = 8'hff; w1c2 = 8'hff; step(); w1c1 = 0; w1c2 = 0;
    chk("R4 clear all", {s1, s2}, 0);

    // R7 R8 mode sweep
    for (int c = 0; c < 8; c++) begin
      stp = c[2]; wt = c[1]; siw = c[0]; #1;
      chk(c[2] ? "R7 stop gate" : "R8 wait gate", ceng, !(c[2] | (c[1] & c[0])));
    end
    stp = 0; wt = 0; siw = 0;

    // R6 R9 falling edge detected while stopped
    stp = 1; rx_pol = 0; rx_pin = 0;
    step(); step();
    chk("R6 no flag before latency", s2, 0);
    step();
    chk("R6 falling edge flag", s2, 8'h80);
    chk("R9 wake in stop", wake, 1);
    chk("R9 engine still gated", ceng, 0);
    irq_en = 7'h10; #1; chk("R5 edge irq", irq, 1); irq_en = 0;
    stp = 0; #1; chk("R9 no wake when running", wake, 0);
    w1c2 = 8'h80; step(); w1c2 = 0; chk("R4 edge clear", s2, 0);
    // opposite edge ignored with pol 0
    rx_pin = 1; repeat (4) step();
    chk("R6 rising ignored pol0", s2, 0);
    // pol 1: rising active, wait+siw gating
    wt = 1; siw = 1; rx_pol = 1; rx_pin = 0; repeat (4) step();
    chk("R6 falling ignored pol1", s2, 0);
    rx_pin = 1; step(); step();
    chk("R6 pol1 not yet", s2, 0);
    step();
    chk("R6 rising edge flag", s2, 8'h80);
    chk("R9 wake in wait", wake, 1);
    wt = 0; siw = 0; w1c2 = 8'h80; step(); w1c2 = 0;

    // R10 reset during stop
    stp = 1; ev_txe = 1; ev_ber = 1; step(); ev_txe = 0; ev_ber = 0;
    chk("R10 flags set pre-reset", {s1, s2}, 16'h8002);
    rst_n = 0; #1;
    chk("R10 reset clears", {s1, s2}, 0);
    step(); rst_n = 1; stp = 0; step();
    chk("R10 stays clear", {s1, s2}, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule